// File: doc/BRIEF.md
# Three-Stage Escalating Watchdog

The block is one watchdog channel behind a small register interface. A down-counter is loaded from a programmed 16-bit length (placed in the upper part of a 24-bit count, low eight bits zero) and steps down once per prescaler period. When a prescaler step finds the count already at zero, the timer expires, reloads and advances an escalation stage. A 2-bit mode decides how far escalation goes: an interrupt on every expiry; an interrupt followed by a management-processor interrupt; or both of those followed by a reset request.

Software keeps the channel alive by writing its channel bit to the poke address. This reloads the count, restarts the prescaler and drops the stage back to idle. The core interrupt comes from a pending flag that is cleared by writing one to it, gated by an enable that has separate write-one-to-set and write-one-to-clear addresses. The reset request stays asserted until the block's own reset is applied.

Top module: `esc_wdog`

## Requirements
- R1: After reset, `core_irq`, `mgmt_irq` and `rst_req` are low. The control, pending and enable registers all read as zero.
- R2: The control register at byte address 8×channel (0x1F8 for channel 63) holds the mode in bits [1:0], the management-interrupt enable in bit 2, the length in bits [19:4] and the live count in bits [43:20], all readable. Writes to the count bits are ignored. The reload value is the length shifted left by eight.
- R3: While running, the count falls by one every 2^PRE_LOG2 clock cycles. The first expiry takes effect (reload_value+1)×2^PRE_LOG2 cycles after the count was loaded, and each later expiry follows after the same interval.
- R4: In mode 1, every expiry sets the pending flag. `mgmt_irq` and `rst_req` stay low.
- R5: In mode 2, the first expiry sets pending and the second raises `mgmt_irq`, provided bit 2 is set. Further expiries never raise `rst_req`.
- R6: In mode 3, the third expiry raises `rst_req`. With bit 2 clear, the second expiry produces no output but still advances the stage, so the reset still follows on the third.
- R7: A write to 0x10000 + 8×channel with data bit [channel] set reloads the count, restarts the prescaler and returns the stage to idle. A poke write with that bit clear has no effect.
- R8: The pending flag reads at bit [channel] of address 0x200. Writing one there clears it and writing zero leaves it unchanged. An expiry in the same cycle wins over the clear.
- R9: Writing one to bit [channel] at 0x218 sets the interrupt enable, and at 0x210 clears it. Both addresses read back the enable at that bit. Pending is set whatever the enable is, and `core_irq` is high exactly when pending and enabled.
- R10: Writing mode 0 stops the timer: the count is held, and the stage and prescaler are cleared. Writing a nonzero mode while the mode is 0 loads the count from the length written in the same access.
- R11: Once `rst_req` rises, it stays high through pokes and mode changes until `rst_n` is asserted.
- R12: `mgmt_irq` is a level. It stays high across later expiries until a poke or a mode-0 write returns the stage to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W (17) | Byte address for reads and writes |
| bus_wdata | input | DATA_W (64) | Write data |
| bus_rdata | output | DATA_W (64) | Combinational read data for `bus_addr` |
| core_irq | output | 1 | Core interrupt: pending AND enable |
| mgmt_irq | output | 1 | Management-processor interrupt level |
| rst_req | output | 1 | Sticky reset request |

## Verification
Register writes take effect at the clock edge that samples `bus_wr`. Every flag, enable and stage change is therefore visible one edge after the write. The bench records that edge and samples just after it. An expiry lands exactly (reload+1)×P edges after the load edge, with P = 2^PRE_LOG2. The bench checks the output low at the edge before that point and set at it, and later expiries at whole multiples of the interval. Writes made in between do not shift the schedule, so the bench computes each due edge from the recorded load edge alone. Count readback is checked just before and just after the first prescaler step, to pin down the step rate.

// File: rtl/esc_wdog_pkg.sv
`timescale 1ns/1ps
package esc_wdog_pkg;
   typedef enum logic [1:0] {
      MD_OFF      = 2'd0,
      MD_IRQ      = 2'd1,
      MD_IRQ_MGMT = 2'd2,
      MD_FULL     = 2'd3
   } wd_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ONE   = 2'd1,
      ST_TWO   = 2'd2,
      ST_THREE = 2'd3
   } wd_stage_e;
endpackage

// File: rtl/esc_wdog_presc.sv
`timescale 1ns/1ps
module esc_wdog_presc #(
   parameter int LOG2 = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic tick
);
   generate
      if (LOG2 == 0) begin : g_direct
         assign tick = run & ~clr;
      end else begin : g_div
         logic [LOG2-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   pre_q <= '0;
            else if (clr) pre_q <= '0;
            else if (run) pre_q <= pre_q + 1'b1;
         end
         assign tick = run & ~clr & (&pre_q);
      end
   endgenerate
endmodule

// File: rtl/esc_wdog_cnt.sv
`timescale 1ns/1ps
module esc_wdog_cnt #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] rld_val,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt_q,
   output logic             expire
);
   assign expire = tick & ~load & (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (load)   cnt_q <= load_val;
      else if (expire) cnt_q <= rld_val;
      else if (tick)   cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/esc_wdog_stage.sv
`timescale 1ns/1ps
module esc_wdog_stage
   import esc_wdog_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clr,
   input  logic      expire,
   input  wd_mode_e  mode,
   output wd_stage_e stage_q,
   output logic      ev_core,
   output logic      ev_rst
);
   wd_stage_e st_d;

   assign ev_core = expire & (mode == MD_IRQ || stage_q == ST_IDLE);
   assign ev_rst  = expire & (mode == MD_FULL) & (stage_q == ST_TWO);

   always_comb begin
      st_d = stage_q;
      if (expire) begin
         unique case (mode)
            MD_IRQ_MGMT: if (stage_q == ST_IDLE || stage_q == ST_ONE)
                            st_d = wd_stage_e'(stage_q + 2'd1);
            MD_FULL:     if (stage_q != ST_THREE)
                            st_d = wd_stage_e'(stage_q + 2'd1);
            default:     st_d = stage_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   stage_q <= ST_IDLE;
      else if (clr) stage_q <= ST_IDLE;
      else          stage_q <= st_d;
   end
endmodule

// File: rtl/esc_wdog.sv
`timescale 1ns/1ps
module esc_wdog
   import esc_wdog_pkg::*;
#(
   parameter int ADDR_W    = 17,
   parameter int DATA_W    = 64,
   parameter int CH_IDX    = 63,
   parameter int LEN_W     = 16,
   parameter int LOW_ZERO  = 8,
   parameter int PRE_LOG2  = 10,
   parameter int INT_ADDR  = 'h200,
   parameter int ENC_ADDR  = 'h210,
   parameter int ENS_ADDR  = 'h218,
   parameter int POKE_BASE = 'h10000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              core_irq,
   output logic              mgmt_irq,
   output logic              rst_req
);
   localparam int CNT_W    = LEN_W + LOW_ZERO;
   localparam int MGMT_BIT = 2;
   localparam int LEN_LSB  = 4;
   localparam int CNT_LSB  = LEN_LSB + LEN_W;
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8 * CH_IDX);
   localparam logic [ADDR_W-1:0] A_POKE = ADDR_W'(POKE_BASE + 8 * CH_IDX);
   localparam logic [ADDR_W-1:0] A_INT  = ADDR_W'(INT_ADDR);
   localparam logic [ADDR_W-1:0] A_ENC  = ADDR_W'(ENC_ADDR);
   localparam logic [ADDR_W-1:0] A_ENS  = ADDR_W'(ENS_ADDR);

   generate
      if (CH_IDX < 0 || CH_IDX >= DATA_W) begin : g_bad_ch
         $error("esc_wdog: CH_IDX outside data word");
      end
      if (CNT_LSB + CNT_W > DATA_W) begin : g_bad_fields
         $error("esc_wdog: control fields exceed data word");
      end
      if (POKE_BASE + 8 * CH_IDX >= (1 << ADDR_W)) begin : g_bad_addr
         $error("esc_wdog: poke address exceeds ADDR_W");
      end
      if (8 * CH_IDX == INT_ADDR || 8 * CH_IDX == ENC_ADDR || 8 * CH_IDX == ENS_ADDR) begin : g_clash
         $error("esc_wdog: control address collides with interrupt registers");
      end
   endgenerate

   wd_mode_e         mode_q;
   logic             mgmt_en_q;
   logic [LEN_W-1:0] len_q;
   logic             pend_q;
   logic             ien_q;
   logic             rst_req_q;

   logic             wr_ctrl, wr_int, wr_enc, wr_ens, poke;
   logic             start, halt, pend_clr, cnt_load, presc_clr, run, tick, expire;
   logic             ev_core, ev_rst;
   wd_mode_e         new_mode;
   logic [LEN_W-1:0] new_len;
   logic [CNT_W-1:0] cnt_q, load_val, rld_val;
   wd_stage_e        stage_q;

   assign wr_ctrl  = bus_wr && bus_addr == A_CTRL;
   assign wr_int   = bus_wr && bus_addr == A_INT;
   assign wr_enc   = bus_wr && bus_addr == A_ENC;
   assign wr_ens   = bus_wr && bus_addr == A_ENS;
   assign poke     = bus_wr && bus_addr == A_POKE && bus_wdata[CH_IDX];
   assign pend_clr = wr_int & bus_wdata[CH_IDX];

   assign new_mode = wd_mode_e'(bus_wdata[1:0]);
   assign new_len  = bus_wdata[LEN_LSB +: LEN_W];
   assign start    = wr_ctrl && mode_q == MD_OFF && new_mode != MD_OFF;
   assign halt     = wr_ctrl && new_mode == MD_OFF;

   assign run       = mode_q != MD_OFF;
   assign cnt_load  = start | poke;
   assign presc_clr = start | halt | poke;
   assign rld_val   = {len_q, {LOW_ZERO{1'b0}}};
   assign load_val  = start ? {new_len, {LOW_ZERO{1'b0}}} : rld_val;

   esc_wdog_presc #(.LOG2(PRE_LOG2)) u_presc (
      .clk(clk), .rst_n(rst_n), .run(run), .clr(presc_clr), .tick(tick)
   );

   esc_wdog_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(load_val),
      .rld_val(rld_val), .tick(tick), .cnt_q(cnt_q), .expire(expire)
   );

   esc_wdog_stage u_stage (
      .clk(clk), .rst_n(rst_n), .clr(presc_clr), .expire(expire),
      .mode(mode_q), .stage_q(stage_q), .ev_core(ev_core), .ev_rst(ev_rst)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= MD_OFF;
         mgmt_en_q <= 1'b0;
         len_q     <= '0;
      end else if (wr_ctrl) begin
         mode_q    <= new_mode;
         mgmt_en_q <= bus_wdata[MGMT_BIT];
         len_q     <= new_len;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_q <= 1'b0;
      else if (ev_core)  pend_q <= 1'b1;
      else if (pend_clr) pend_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             ien_q <= 1'b0;
      else if (wr_ens && bus_wdata[CH_IDX])   ien_q <= 1'b1;
      else if (wr_enc && bus_wdata[CH_IDX])   ien_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rst_req_q <= 1'b0;
      else if (ev_rst) rst_req_q <= 1'b1;
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_CTRL: begin
            bus_rdata[1:0]                 = mode_q;
            bus_rdata[MGMT_BIT]            = mgmt_en_q;
            bus_rdata[LEN_LSB +: LEN_W]    = len_q;
            bus_rdata[CNT_LSB +: CNT_W]    = cnt_q;
         end
         A_INT:          bus_rdata[CH_IDX] = pend_q;
         A_ENC, A_ENS:   bus_rdata[CH_IDX] = ien_q;
         default:        bus_rdata = '0;
      endcase
   end

   assign core_irq = pend_q & ien_q;
   assign mgmt_irq = mgmt_en_q && (mode_q == MD_IRQ_MGMT || mode_q == MD_FULL)
                     && (stage_q == ST_TWO || stage_q == ST_THREE);
   assign rst_req  = rst_req_q;
endmodule

// File: rtl/esc_wdog_chk.sv
`timescale 1ns/1ps
module esc_wdog_chk #(
   parameter int CNT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode,
   input logic [1:0]       stage,
   input logic [CNT_W-1:0] cnt,
   input logic             load,
   input logic             tick,
   input logic             pend,
   input logic             pend_clr,
   input logic             ev_core,
   input logic             poke,
   input logic             rst_req
);
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> rst_req); // R11

   AST_RST_FULL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $rose(rst_req)) |-> $past(mode) == 2'd3); // R6

   AST_POKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(poke)) |-> stage == 2'd0); // R7

   AST_PEND_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(pend_clr) && !$past(ev_core)) |-> !pend); // R8

   AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(mode) == 2'd0 && !$past(load)) |-> $stable(cnt)); // R10

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(tick) && !$past(load) && $past(cnt) != '0)
         |-> cnt == $past(cnt) - CNT_W'(1)); // R3
endmodule

bind esc_wdog esc_wdog_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode_q), .stage(stage_q), .cnt(cnt_q),
   .load(cnt_load), .tick(tick), .pend(pend_q), .pend_clr(pend_clr),
   .ev_core(ev_core), .poke(poke), .rst_req(rst_req)
);

// File: tb/esc_wdog_tb.sv
`timescale 1ns/1ps
module esc_wdog_tb;
   localparam int PL = 2;
   localparam int P  = 1 << PL;
   localparam logic [16:0] A_CTRL = 17'h1F8;
   localparam logic [16:0] A_INT  = 17'h200;
   localparam logic [16:0] A_ENC  = 17'h210;
   localparam logic [16:0] A_ENS  = 17'h218;
   localparam logic [16:0] A_POKE = 17'h101F8;
   localparam logic [63:0] BIT    = 64'h1 << 63;

   logic        clk = 0, rst_n = 0, bus_wr = 0;
   logic [16:0] bus_addr = '0;
   logic [63:0] bus_wdata = '0, bus_rdata, rv;
   logic        core_irq, mgmt_irq, rst_req;
   int checks = 0, errors = 0, cyc = 0, t0 = 0, e = 0;
   bit done = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   esc_wdog #(.PRE_LOG2(PL)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .core_irq(core_irq), .mgmt_irq(mgmt_irq), .rst_req(rst_req)
   );

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic wr(logic [16:0] a, logic [63:0] d);
      @(negedge clk);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 0;
      t0 = cyc;
   endtask

   task automatic rd(logic [16:0] a, output logic [63:0] d);
      bus_addr = a; #0.2;
      d = bus_rdata;
   endtask

   task automatic at(int target);
      while (cyc < target) begin
         @(posedge clk); #1;
      end
   endtask

   function automatic int period(int len);
      return (len * 256 + 1) * P;
   endfunction

   initial begin
      #1_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog timeout actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int T;
      T = period(1);
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      @(posedge clk); #1;

      // R1 reset state
      check("R1 core_irq", core_irq, 0);
      check("R1 mgmt_irq", mgmt_irq, 0);
      check("R1 rst_req", rst_req, 0);
      rd(A_CTRL, rv); check("R1 ctrl", rv, 0);
      rd(A_INT, rv);  check("R1 pending", rv, 0);
      rd(A_ENS, rv);  check("R1 enable", rv, 0);

      // R9 enable set
      wr(A_ENS, BIT);
      rd(A_ENS, rv); check("R9 enable set", rv, BIT);

      // R2/R10 start mode 1, length 1
      wr(A_CTRL, (64'd1 << 4) | 64'hF00_0000_0001); e = t0;
      rd(A_CTRL, rv);
      check("R2 mode", rv[1:0], 1);
      check("R2 length", rv[19:4], 1);
      check("R10 count loaded", rv[43:20], 256);
      at(e + P - 1); rd(A_CTRL, rv); check("R3 count before step", rv[43:20], 256);
      at(e + P);     rd(A_CTRL, rv); check("R3 count after step", rv[43:20], 255);
      at(e + T - 1); check("R3 irq before expiry", core_irq, 0);
      at(e + T);     check("R3 irq at expiry", core_irq, 1);
      rd(A_INT, rv); check("R4 pending", rv, BIT);
      check("R4 no mgmt", mgmt_irq, 0);
      wr(A_INT, 0);  rd(A_INT, rv); check("R8 write zero", rv, BIT);
      wr(A_INT, BIT); rd(A_INT, rv); check("R8 w1c", rv, 0);
      check("R8 irq low", core_irq, 0);
      at(e + 2 * T); check("R4 second expiry", core_irq, 1);
      check("R4 no reset", rst_req, 0);
      wr(A_ENC, BIT);
      check("R9 gated off", core_irq, 0);
      rd(A_INT, rv); check("R9 pending kept", rv, BIT);
      wr(A_ENS, BIT); check("R9 gated on", core_irq, 1);

      // R3 length sweep in mode 1
      for (int l = 1; l <= 3; l++) begin
         wr(A_CTRL, 64'(l) << 4);
         wr(A_INT, BIT);
         wr(A_CTRL, (64'(l) << 4) | 1); e = t0;
         at(e + period(l) - 1); rd(A_INT, rv); check("R3 sweep before", rv, 0);
         at(e + period(l));     rd(A_INT, rv); check("R3 sweep at", rv, BIT);
      end

      // R10 halt holds count
      wr(A_CTRL, 64'd1 << 4);
      wr(A_INT, BIT);
      rd(A_CTRL, rv);
      begin
         logic [63:0] held;
         held = rv;
         at(t0 + 3000); rd(A_CTRL, rv);
         check("R10 count held", rv[43:20], held[43:20]);
         check("R10 no irq", core_irq, 0);
      end

      // R5/R7/R12 mode 2 with management enabled, enable off
      wr(A_ENC, BIT);
      wr(A_CTRL, (64'd1 << 4) | 64'h4 | 2); e = t0;
      at(e + T - 10);
      wr(A_POKE, BIT); e = t0;
      at(e + T - 1); rd(A_INT, rv); check("R7 poke delayed", rv, 0);
      at(e + T);     rd(A_INT, rv); check("R9 pending without enable", rv, BIT);
      check("R9 irq gated", core_irq, 0);
      at(e + 2 * T - 10);
      wr(A_POKE, 64'h1);
      at(e + 2 * T - 1); check("R5 mgmt before", mgmt_irq, 0);
      at(e + 2 * T);     check("R7 bad poke ignored / R5 mgmt", mgmt_irq, 1);
      at(e + 4 * T);     check("R5 no reset", rst_req, 0);
      check("R12 mgmt held", mgmt_irq, 1);
      wr(A_POKE, BIT);   check("R12 poke drops mgmt", mgmt_irq, 0);

      // R6/R11 mode 3, management disabled
      wr(A_CTRL, 64'd1 << 4);
      wr(A_INT, BIT);
      wr(A_CTRL, (64'd1 << 4) | 3); e = t0;
      at(e + T);         rd(A_INT, rv); check("R6 first pending", rv, BIT);
      at(e + 2 * T);     check("R6 silent second", mgmt_irq, 0);
      check("R6 no reset yet", rst_req, 0);
      at(e + 3 * T - 1); check("R6 reset before", rst_req, 0);
      at(e + 3 * T);     check("R6 reset at third", rst_req, 1);
      wr(A_POKE, BIT);   check("R11 poke keeps reset", rst_req, 1);
      wr(A_CTRL, 0);     check("R11 halt keeps reset", rst_req, 1);
      @(negedge clk); rst_n = 0;
      @(posedge clk); #1;
      check("R11 reset clears", rst_req, 0);
      @(negedge clk); rst_n = 1;
      @(posedge clk); #1;
      rd(A_CTRL, rv); check("R1 ctrl after reset", rv, 0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule